// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block keeps one captured time value for each traffic direction, receive and transmit. A packet matcher outside the block raises a one-cycle event strobe together with the sequence identifier of the packet. If the buffer for that direction is empty and capture is enabled, the buffer stores the current 64-bit time and the sequence identifier. The buffer then stays full until the host frees it. While it is full, later events on that direction are lost.

The host reaches each buffer through a small register window: a status word, a low time word and a high time word. To release a buffer, the host writes a one into the valid-flag position of that buffer's status word. A configuration flush input empties both buffers at once. It is meant to be pulsed whenever timestamping is enabled or its filtering is changed, so that stale captures are dropped.

Each direction is driven by a two-state machine. In state SLOT_EMPTY the buffer waits. The transition T_CAPTURE moves it to SLOT_HELD on an enabled event, but only when no release or flush arrives in the same cycle. In SLOT_HELD the buffer keeps its value. The transition T_RELEASE (host write-one-to-clear) or T_FLUSH (configuration flush) returns it to SLOT_EMPTY. On that return the stored time and sequence identifier are zeroed.

Top module: `ts_capture_latch`

## Requirements
- R1: After reset both buffers are in SLOT_EMPTY, and every register address reads 0.
- R2: An event on an empty buffer with its enable high stores the time input and the sequence input sampled at that clock edge. From the next cycle, the status word reads bit 16 = 1 and bits 15:0 = the sequence identifier. The low word holds time bits 31:0 and the high word holds time bits 63:32.
- R3: The register address is 3 bits. Address bit 2 selects the direction (0 receive, 1 transmit). Address bits 1:0 select the word: 0 status, 1 low time word, 2 high time word. Selector value 3 reads 0. Status bits 31:17 always read 0.
- R4: A host write to a direction's status address with write data bit 16 = 1 empties that buffer in the next cycle. A write with bit 16 = 0, or a write to a time-word address, has no effect.
- R5: An event that arrives while a buffer is in SLOT_HELD is ignored. The stored time and sequence identifier are kept.
- R6: When a release write and an event for the same direction arrive in the same cycle, the release wins. The buffer is empty afterwards, whether it was empty or full before.
- R7: A flush pulse empties both buffers in the next cycle. It also wins over events that arrive in the same cycle.
- R8: While a direction's enable is low, events on that direction cause no capture.
- R9: The two directions are independent. An event, release or enable on one direction never changes the other.
- R10: While a buffer is empty, its status bits 15:0 and both of its time words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Current time counter value |
| rx_evt | input | 1 | Receive packet event strobe |
| rx_seq | input | 16 | Receive packet sequence identifier |
| rx_en | input | 1 | Receive capture enable |
| tx_evt | input | 1 | Transmit packet event strobe |
| tx_seq | input | 16 | Transmit packet sequence identifier |
| tx_en | input | 1 | Transmit capture enable |
| cfg_flush | input | 1 | Empties both buffers (pulse on timestamp enable or reconfiguration) |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational from the address) |

## Verification
The hardest cases to reach are the collisions: a release write landing in exactly the same cycle as a packet event, and a flush meeting an event. The bench handles these by setting the write strobe, the event and the flush together on one falling edge, so that they all meet the same rising edge. It covers both a held buffer and an empty buffer. It then reads the status word to confirm that the buffer is empty. Dropped events on a held buffer are shown by reading back the first captured time and sequence identifier after a second event that carries different values.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
    localparam int NDIR    = 2;
    localparam int DIR_RX  = 0;
    localparam int DIR_TX  = 1;
    localparam int REG_W   = 32;
    localparam int SEQ_W   = 16;
    localparam int VLD_BIT = 16;
    localparam int TS_W    = 64;
    localparam int SEL_W   = 2;
    localparam int ADDR_W  = $clog2(NDIR) + SEL_W;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    typedef enum logic [SEL_W-1:0] {
        REG_STATUS = 2'd0,
        REG_TS_LO  = 2'd1,
        REG_TS_HI  = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ts_cap_slot.sv
module ts_cap_slot
    import ts_cap_pkg::*;
#(
    parameter int P_TS_W  = TS_W,
    parameter int P_SEQ_W = SEQ_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               evt_i,
    input  logic [P_SEQ_W-1:0] seq_i,
    input  logic [P_TS_W-1:0]  time_i,
    input  logic               release_i,
    input  logic               flush_i,
    output logic               valid_o,
    output logic [P_SEQ_W-1:0] seq_o,
    output logic [P_TS_W-1:0]  ts_o
);
    slot_state_e state_q, state_d;
    logic        drop;
    logic        take;
    logic        free;

    assign drop = release_i | flush_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (!drop && evt_i && en_i) state_d = SLOT_HELD;  // T_CAPTURE
            SLOT_HELD:  if (drop)                   state_d = SLOT_EMPTY; // T_RELEASE / T_FLUSH
            default:                                state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    assign take = (state_q == SLOT_EMPTY) && (state_d == SLOT_HELD);
    assign free = (state_q == SLOT_HELD)  && (state_d == SLOT_EMPTY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_o  <= '0;
            seq_o <= '0;
        end else if (take) begin
            ts_o  <= time_i;
            seq_o <= seq_i;
        end else if (free) begin
            ts_o  <= '0;
            seq_o <= '0;
        end
    end

    assign valid_o = (state_q == SLOT_HELD);
endmodule

// File: rtl/ts_cap_regif.sv
module ts_cap_regif
    import ts_cap_pkg::*;
#(
    parameter int P_NDIR  = NDIR,
    parameter int P_TS_W  = TS_W,
    parameter int P_SEQ_W = SEQ_W,
    parameter int P_REG_W = REG_W,
    parameter int P_VBIT  = VLD_BIT
) (
    input  logic                            host_we,
    input  logic [ADDR_W-1:0]               host_addr,
    input  logic [P_REG_W-1:0]              host_wdata,
    input  logic [P_NDIR-1:0]               valid_i,
    input  logic [P_NDIR-1:0][P_SEQ_W-1:0]  seq_i,
    input  logic [P_NDIR-1:0][P_TS_W-1:0]   ts_i,
    output logic [P_NDIR-1:0]               release_o,
    output logic [P_REG_W-1:0]              host_rdata
);
    localparam int DIR_W = ADDR_W - SEL_W;

    logic [DIR_W-1:0] dir;
    reg_sel_e         sel;

    assign dir = host_addr[ADDR_W-1:SEL_W];
    assign sel = reg_sel_e'(host_addr[SEL_W-1:0]);

    for (genvar d = 0; d < P_NDIR; d++) begin : g_rel
        assign release_o[d] = host_we && (dir == DIR_W'(d)) &&
                              (sel == REG_STATUS) && host_wdata[P_VBIT];
    end

    always_comb begin
        host_rdata = '0;
        unique case (sel)
            REG_STATUS: begin
                host_rdata[P_SEQ_W-1:0] = seq_i[dir];
                host_rdata[P_VBIT]      = valid_i[dir];
            end
            REG_TS_LO:  host_rdata = ts_i[dir][P_REG_W-1:0];
            REG_TS_HI:  host_rdata = ts_i[dir][2*P_REG_W-1:P_REG_W];
            REG_NONE:   host_rdata = '0;
            default:    host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ts_capture_latch.sv
module ts_capture_latch
    import ts_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   time_now,
    input  logic              rx_evt,
    input  logic [SEQ_W-1:0]  rx_seq,
    input  logic              rx_en,
    input  logic              tx_evt,
    input  logic [SEQ_W-1:0]  tx_seq,
    input  logic              tx_en,
    input  logic              cfg_flush,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata
);
    logic [NDIR-1:0]             evt_v;
    logic [NDIR-1:0]             en_v;
    logic [NDIR-1:0][SEQ_W-1:0]  seq_v;
    logic [NDIR-1:0]             slot_vld;
    logic [NDIR-1:0]             slot_rel;
    logic [NDIR-1:0][SEQ_W-1:0]  slot_seq;
    logic [NDIR-1:0][TS_W-1:0]   slot_ts;

    assign evt_v[DIR_RX] = rx_evt;
    assign evt_v[DIR_TX] = tx_evt;
    assign en_v[DIR_RX]  = rx_en;
    assign en_v[DIR_TX]  = tx_en;
    assign seq_v[DIR_RX] = rx_seq;
    assign seq_v[DIR_TX] = tx_seq;

    for (genvar d = 0; d < NDIR; d++) begin : g_slot
        ts_cap_slot #(.P_TS_W(TS_W), .P_SEQ_W(SEQ_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (en_v[d]),
            .evt_i     (evt_v[d]),
            .seq_i     (seq_v[d]),
            .time_i    (time_now),
            .release_i (slot_rel[d]),
            .flush_i   (cfg_flush),
            .valid_o   (slot_vld[d]),
            .seq_o     (slot_seq[d]),
            .ts_o      (slot_ts[d])
        );
    end

    ts_cap_regif #(
        .P_NDIR (NDIR),
        .P_TS_W (TS_W),
        .P_SEQ_W(SEQ_W),
        .P_REG_W(REG_W),
        .P_VBIT (VLD_BIT)
    ) u_regif (
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .valid_i   (slot_vld),
        .seq_i     (slot_seq),
        .ts_i      (slot_ts),
        .release_o (slot_rel),
        .host_rdata(host_rdata)
    );
endmodule

// File: rtl/ts_capture_latch_chk.sv
module ts_capture_latch_chk
    import ts_cap_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic [TS_W-1:0]              time_now,
    input logic [NDIR-1:0]              evt,
    input logic [NDIR-1:0]              en,
    input logic [NDIR-1:0]              rel,
    input logic                         flush,
    input logic [NDIR-1:0]              vld,
    input logic [NDIR-1:0][SEQ_W-1:0]   seq,
    input logic [NDIR-1:0][TS_W-1:0]    ts
);
    for (genvar d = 0; d < NDIR; d++) begin : g_chk
        p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!vld[d] && evt[d] && en[d] && !rel[d] && !flush)
            |=> (vld[d] && ts[d] == $past(time_now)));

        p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (vld[d] && !rel[d] && !flush)
            |=> (vld[d] && $stable(ts[d]) && $stable(seq[d])));

        p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
            rel[d] |=> !vld[d]);

        p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
            flush |=> !vld[d]);

        p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!vld[d] && !en[d]) |=> !vld[d]);

        p_empty_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !vld[d] |-> (ts[d] == '0 && seq[d] == '0));
    end
endmodule

bind ts_capture_latch ts_capture_latch_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .time_now(time_now),
    .evt     (evt_v),
    .en      (en_v),
    .rel     (slot_rel),
    .flush   (cfg_flush),
    .vld     (slot_vld),
    .seq     (slot_seq),
    .ts      (slot_ts)
);

// File: tb/ts_capture_latch_tb.sv
module ts_capture_latch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = '0;
    logic        rx_evt = 1'b0, tx_evt = 1'b0;
    logic [15:0] rx_seq = '0, tx_seq = '0;
    logic        rx_en = 1'b0, tx_en = 1'b0;
    logic        cfg_flush = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ts_capture_latch u_dut (
        .clk(clk), .rst_n(rst_n), .time_now(time_now),
        .rx_evt(rx_evt), .rx_seq(rx_seq), .rx_en(rx_en),
        .tx_evt(tx_evt), .tx_seq(tx_seq), .tx_en(tx_en),
        .cfg_flush(cfg_flush), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        host_addr = a;
        #1;
        check(req, host_rdata, exp);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        rx_evt = 1'b0; tx_evt = 1'b0; host_we = 1'b0; cfg_flush = 1'b0;
    endtask

    task automatic host_write(input logic [2:0] a, input logic [31:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        step();
    endtask

    task automatic rx_event(input logic [63:0] t, input logic [15:0] s);
        time_now = t; rx_seq = s; rx_evt = 1'b1;
        step();
    endtask

    task automatic tx_event(input logic [63:0] t, input logic [15:0] s);
        time_now = t; tx_seq = s; tx_evt = 1'b1;
        step();
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd_check("R1 reset read", 3'(a), 32'h0);
    endtask

    task automatic t_capture();
        rx_en = 1'b1;
        rx_event(64'hA5A5_0001_DEAD_BEEF, 16'h1234);
        rd_check("R2 rx status", 3'd0, 32'h0001_1234);
        rd_check("R2 rx low", 3'd1, 32'hDEAD_BEEF);
        rd_check("R2 rx high", 3'd2, 32'hA5A5_0001);
        rd_check("R3 selector 3 reads zero", 3'd3, 32'h0);
        rd_check("R9 tx untouched by rx event", 3'd4, 32'h0);
    endtask

    task automatic t_sticky();
        rx_event(64'h1111_2222_3333_4444, 16'h7777);
        rd_check("R5 status kept", 3'd0, 32'h0001_1234);
        rd_check("R5 low kept", 3'd1, 32'hDEAD_BEEF);
        rd_check("R5 high kept", 3'd2, 32'hA5A5_0001);
    endtask

    task automatic t_release();
        host_write(3'd0, 32'hFFFE_FFFF);
        rd_check("R4 write without bit16 ignored", 3'd0, 32'h0001_1234);
        host_write(3'd1, 32'h0001_0000);
        rd_check("R4 write to low word ignored", 3'd0, 32'h0001_1234);
        host_write(3'd4, 32'h0001_0000);
        rd_check("R9 tx release leaves rx", 3'd0, 32'h0001_1234);
        host_write(3'd0, 32'h0001_0000);
        rd_check("R4 released status", 3'd0, 32'h0);
        rd_check("R10 empty low", 3'd1, 32'h0);
        rd_check("R10 empty high", 3'd2, 32'h0);
        rx_event(64'h0000_0002_0000_0010, 16'hBEEF);
        rd_check("R4 recapture after release", 3'd0, 32'h0001_BEEF);
        rd_check("R4 recapture low", 3'd1, 32'h0000_0010);
    endtask

    task automatic t_race();
        host_we = 1'b1; host_addr = 3'd0; host_wdata = 32'h0001_0000;
        time_now = 64'h9; rx_seq = 16'h0042; rx_evt = 1'b1;
        step();
        rd_check("R6 held: release beats event", 3'd0, 32'h0);
        host_we = 1'b1; host_addr = 3'd0; host_wdata = 32'h0001_0000;
        time_now = 64'hA; rx_seq = 16'h0043; rx_evt = 1'b1;
        step();
        rd_check("R6 empty: release beats event", 3'd0, 32'h0);
        rd_check("R6 empty low", 3'd1, 32'h0);
    endtask

    task automatic t_gate();
        rx_en = 1'b0; tx_en = 1'b0;
        rx_event(64'h5, 16'h0005);
        rd_check("R8 rx disabled", 3'd0, 32'h0);
        tx_event(64'h6, 16'h0006);
        rd_check("R8 tx disabled", 3'd4, 32'h0);
    endtask

    task automatic t_tx();
        tx_en = 1'b1;
        tx_event(64'h0123_4567_89AB_CDEF, 16'hFFFF);
        rd_check("R2 tx status", 3'd4, 32'h0001_FFFF);
        rd_check("R3 tx low", 3'd5, 32'h89AB_CDEF);
        rd_check("R3 tx high", 3'd6, 32'h0123_4567);
        rd_check("R3 tx selector 3", 3'd7, 32'h0);
        rd_check("R9 rx untouched by tx", 3'd0, 32'h0);
    endtask

    task automatic t_flush();
        rx_en = 1'b1;
        rx_event(64'h77, 16'h0077);
        rd_check("R2 rx before flush", 3'd0, 32'h0001_0077);
        cfg_flush = 1'b1;
        step();
        rd_check("R7 rx flushed", 3'd0, 32'h0);
        rd_check("R7 tx flushed", 3'd4, 32'h0);
        rd_check("R7 tx low zero", 3'd5, 32'h0);
        cfg_flush = 1'b1; time_now = 64'h88;
        rx_seq = 16'h0088; rx_evt = 1'b1;
        tx_seq = 16'h0099; tx_evt = 1'b1;
        step();
        rd_check("R7 flush beats rx event", 3'd0, 32'h0);
        rd_check("R7 flush beats tx event", 3'd4, 32'h0);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture();
        t_sticky();
        t_release();
        t_race();
        t_gate();
        t_tx();
        t_flush();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule